// File: doc/BRIEF.md
# PTP Receive Frame Buffer Controller

This block stores received precision-time-protocol frames in a ring of fixed-size bins. Host software drains the bins. Each incoming data beat is written into the bin that the write pointer selects, at the next word offset in that bin. A frame that ends with a good status closes its bin. The write pointer then moves to the next bin, the number of the closed bin is latched as the most recent one, and an interrupt is raised.

The host reads bin contents through a separate RAM read port. It moves a read pointer forward by one bin for each bin it releases. One control/status register holds a clear command and shows the number of the most recently filled bin. Writing the clear command drops all bins not yet consumed by setting the write pointer to the read pointer. Any read or write of this register acknowledges the interrupt.

Top module: `ptp_rxbuf_ctrl`

## Requirements
- R1: After reset `irq` is 0, `reg_rdata` is 0, and the most-recent-bin field reads 0.
- R2: A beat with `rx_valid`, `rx_eof` high and `rx_bad` low closes the current bin. Its number then reads in bits 11:8 of the control register at offset 0x2004, and the next frame fills the following bin. Bin numbers wrap from 15 to 0.
- R3: A frame whose last beat has `rx_bad` high does not move the write pointer, does not change the reported bin and does not raise `irq`. The next good frame reuses the same bin.
- R4: `irq` goes high on the clock edge that takes a good end-of-frame beat and stays high until it is acknowledged.
- R5: A read (`reg_rd`) or a write (`reg_wr`) at offset 0x2004 drops `irq` at the next edge. An access at any other offset leaves `irq` unchanged.
- R6: If a good end-of-frame beat and a control-register access fall in the same cycle, `irq` is high afterwards.
- R7: Writing the control register with bit 0 = 1 sets the write pointer to the read pointer, so the next good frame fills the bin the read pointer selects. Writing bit 0 = 0 leaves the write pointer unchanged.
- R8: A read returns its data in `reg_rdata` one cycle after `reg_rd`. At 0x2004, bit 0 and bits 7:1 and 31:12 read 0. Reads at other offsets return 0.
- R9: The beats of a frame are stored at word offsets 0, 1, 2, … of their bin. Driving `mem_rbin`/`mem_rword` returns that word on `mem_rdata` one cycle later.
- R10: Each cycle with `bin_release` high moves the read pointer on by one bin, modulo 16.
- R11: Beats beyond the bin capacity of 16 words are dropped, so earlier words in the bin keep their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Frame data beat valid |
| rx_data | input | 32 | Frame data beat |
| rx_eof | input | 1 | Beat is the last of its frame |
| rx_bad | input | 1 | Frame failed checks (qualifies `rx_eof`) |
| bin_release | input | 1 | Host has consumed one bin; advance read pointer |
| mem_rbin | input | 4 | Bin number for host RAM read |
| mem_rword | input | 4 | Word offset for host RAM read |
| mem_rdata | output | 32 | RAM read data, one cycle after address |
| reg_addr | input | 16 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Frame-received interrupt |

## Verification
A wrong write pointer shows up at the ports at the next good frame. The register field reports a bin number other than the expected one, and the frame data appears in a bin other than the expected one when read back. A lost set or a late clear of the interrupt shows on `irq` one cycle after the edge that caused it. The bench therefore samples `irq` right after each frame end and each register access. A bad-frame or clear error that changes a pointer stays hidden until the next good frame. For that reason every such scenario ends with a good frame and a register read.

// File: rtl/ptp_rxbuf_pkg.sv
package ptp_rxbuf_pkg;
  // Bit layout of the control/status word
  localparam int CLR_BIT = 0;
  localparam int BIN_LSB = 8;

  function automatic logic [31:0] status_mask(input int bin_w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < bin_w; i++) m[BIN_LSB + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ptp_rxbuf_ram.sv
module ptp_rxbuf_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ptp_rxbuf_ptrs.sv
module ptp_rxbuf_ptrs #(
  parameter int BIN_W  = 4,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid,
  input  logic              beat_eof,
  input  logic              beat_bad,
  input  logic              clear_cmd,
  input  logic              rd_adv,
  output logic              mem_we,
  output logic [BIN_W-1:0]  wr_bin,
  output logic [WORD_W-1:0] wr_word,
  output logic [BIN_W-1:0]  rd_bin,
  output logic [BIN_W-1:0]  last_bin,
  output logic              frame_done
);
  // extra top bit flags a bin that has filled up
  logic [WORD_W:0]   word_cnt;
  logic [BIN_W-1:0]  rd_bin_nxt;

  assign frame_done = beat_valid && beat_eof && !beat_bad;
  assign mem_we     = beat_valid && !word_cnt[WORD_W];
  assign wr_word    = word_cnt[WORD_W-1:0];
  assign rd_bin_nxt = rd_adv ? rd_bin + 1'b1 : rd_bin;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_cnt <= '0;
    end else if (beat_valid) begin
      if (beat_eof)                word_cnt <= '0;
      else if (!word_cnt[WORD_W])  word_cnt <= word_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin   <= '0;
      wr_bin   <= '0;
      last_bin <= '0;
    end else begin
      rd_bin <= rd_bin_nxt;
      if (clear_cmd)       wr_bin <= rd_bin_nxt;
      else if (frame_done) wr_bin <= wr_bin + 1'b1;
      if (frame_done)      last_bin <= wr_bin;
    end
  end
endmodule

// File: rtl/ptp_rxbuf_regs.sv
module ptp_rxbuf_regs
  import ptp_rxbuf_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REG_W       = 32,
  parameter int BIN_W       = 4,
  parameter int CTRL_OFFSET = 'h2004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              clr_bit,
  input  logic              reg_rd,
  input  logic [BIN_W-1:0]  last_bin,
  input  logic              frame_done,
  output logic              clear_cmd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic             hit;
  logic [REG_W-1:0] status_word;

  assign hit       = (reg_addr == ADDR_W'(CTRL_OFFSET));
  assign clear_cmd = reg_wr && hit && clr_bit;

  always_comb begin
    status_word = '0;
    status_word[BIN_LSB +: BIN_W] = last_bin;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= hit ? status_word : '0;
  end

  // a new reception outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                         irq <= 1'b0;
    else if (frame_done)             irq <= 1'b1;
    else if ((reg_rd || reg_wr) && hit) irq <= 1'b0;
  end
endmodule

// File: rtl/ptp_rxbuf_ctrl.sv
module ptp_rxbuf_ctrl
  import ptp_rxbuf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BIN_W       = 4,
  parameter int WORD_W      = 4,
  parameter int ADDR_W      = 16,
  parameter int REG_W       = 32,
  parameter int CTRL_OFFSET = 'h2004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eof,
  input  logic              rx_bad,
  input  logic              bin_release,
  input  logic [BIN_W-1:0]  mem_rbin,
  input  logic [WORD_W-1:0] mem_rword,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int RAM_AW = BIN_W + WORD_W;

  logic              mem_we;
  logic [BIN_W-1:0]  wr_bin;
  logic [WORD_W-1:0] wr_word;
  logic [BIN_W-1:0]  rd_bin;
  logic [BIN_W-1:0]  last_bin;
  logic              frame_done;
  logic              clear_cmd;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[REG_W-1:1];

  ptp_rxbuf_ptrs #(.BIN_W(BIN_W), .WORD_W(WORD_W)) u_ptrs (
    .clk(clk), .rst(rst),
    .beat_valid(rx_valid), .beat_eof(rx_eof), .beat_bad(rx_bad),
    .clear_cmd(clear_cmd), .rd_adv(bin_release),
    .mem_we(mem_we), .wr_bin(wr_bin), .wr_word(wr_word),
    .rd_bin(rd_bin), .last_bin(last_bin), .frame_done(frame_done)
  );

  ptp_rxbuf_regs #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .BIN_W(BIN_W), .CTRL_OFFSET(CTRL_OFFSET)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .clr_bit(reg_wdata[CLR_BIT]),
    .reg_rd(reg_rd), .last_bin(last_bin), .frame_done(frame_done),
    .clear_cmd(clear_cmd), .reg_rdata(reg_rdata), .irq(irq)
  );

  ptp_rxbuf_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(mem_we),
    .waddr({wr_bin, wr_word}), .wdata(rx_data),
    .raddr({mem_rbin, mem_rword}), .rdata(mem_rdata)
  );
endmodule

// File: rtl/ptp_rxbuf_chk.sv
module ptp_rxbuf_chk
  import ptp_rxbuf_pkg::*;
#(
  parameter int BIN_W       = 4,
  parameter int ADDR_W      = 16,
  parameter int REG_W       = 32,
  parameter int CTRL_OFFSET = 'h2004
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_eof,
  input logic              rx_bad,
  input logic              bin_release,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq,
  input logic              clear_cmd,
  input logic [BIN_W-1:0]  wr_bin,
  input logic [BIN_W-1:0]  rd_bin
);
  localparam logic [31:0] FIELD = status_mask(BIN_W);

  logic good_end, bad_end, ctrl_acc;
  assign good_end = rx_valid && rx_eof && !rx_bad;
  assign bad_end  = rx_valid && rx_eof && rx_bad;
  assign ctrl_acc = (reg_rd || reg_wr) && (reg_addr == ADDR_W'(CTRL_OFFSET));

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && reg_rdata == '0));
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (good_end && !clear_cmd) |=> wr_bin == BIN_W'($past(wr_bin) + 1'b1));
  a_r3_bad_hold: assert property (@(posedge clk) disable iff (rst)
    (bad_end && !clear_cmd) |=> $stable(wr_bin));
  a_r3_bad_no_irq: assert property (@(posedge clk) disable iff (rst)
    (bad_end && !irq) |=> !irq);
  a_r4_irq_set: assert property (@(posedge clk) disable iff (rst)
    good_end |=> irq);
  a_r5_ack: assert property (@(posedge clk) disable iff (rst)
    (ctrl_acc && !good_end) |=> !irq);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ctrl_acc && good_end) |=> irq);
  a_r7_clear_align: assert property (@(posedge clk) disable iff (rst)
    (clear_cmd && !bin_release) |=> wr_bin == rd_bin);
  a_r8_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~REG_W'(FIELD)) == '0);
  a_r10_rd_step: assert property (@(posedge clk) disable iff (rst)
    bin_release |=> rd_bin == BIN_W'($past(rd_bin) + 1'b1));
endmodule

bind ptp_rxbuf_ctrl ptp_rxbuf_chk #(
  .BIN_W(BIN_W), .ADDR_W(ADDR_W), .REG_W(REG_W), .CTRL_OFFSET(CTRL_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_bad(rx_bad),
  .bin_release(bin_release), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq),
  .clear_cmd(clear_cmd), .wr_bin(wr_bin), .rd_bin(rd_bin)
);

// File: tb/sim_ptp_rxbuf_ctrl.sv
module sim_ptp_rxbuf_ctrl;
  localparam logic [15:0] CTRL = 16'h2004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, rx_eof = 0, rx_bad = 0, bin_release = 0;
  logic [31:0] rx_data = '0;
  logic [3:0]  mem_rbin = '0, mem_rword = '0;
  logic [31:0] mem_rdata;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int exp_wr = 0, exp_rd = 0;

  always #2 clk = ~clk;

  ptp_rxbuf_ctrl u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_bad(rx_bad), .bin_release(bin_release),
    .mem_rbin(mem_rbin), .mem_rword(mem_rword), .mem_rdata(mem_rdata),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int beats, input bit bad, input logic [15:0] tag);
    for (int i = 0; i < beats; i++) begin
      rx_valid = 1; rx_data = {tag, 16'(i)};
      rx_eof = (i == beats - 1); rx_bad = bad && (i == beats - 1);
      @(negedge clk);
    end
    rx_valid = 0; rx_eof = 0; rx_bad = 0;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0; d = reg_rdata;
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic mem_read(input int b, input int w, output logic [31:0] d);
    mem_rbin = 4'(b); mem_rword = 4'(w);
    @(negedge clk);
    d = mem_rdata;
  endtask

  task automatic release_bins(input int n);
    for (int i = 0; i < n; i++) begin
      bin_release = 1; @(negedge clk); exp_rd = (exp_rd + 1) % 16;
    end
    bin_release = 0;
  endtask

  task automatic check_last(input string req);
    logic [31:0] d;
    reg_read(CTRL, d);
    chk(d == {20'b0, 4'(exp_wr), 8'b0}, req, d, {20'b0, 4'(exp_wr), 8'b0});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    reg_read(CTRL, d);
    chk(d == 0, "R1 field", d, 0);
  endtask

  task automatic t_good();
    logic [31:0] d;
    send_frame(4, 0, 16'hA000);
    chk(irq == 1, "R4 irq set", 32'(irq), 1);
    @(negedge clk);
    chk(irq == 1, "R4 irq held", 32'(irq), 1);
    reg_read(CTRL, d);
    chk(d == 32'h0, "R2 R8 bin0 read", d, 0);
    chk(irq == 0, "R5 read ack", 32'(irq), 0);
    for (int w = 0; w < 4; w++) begin
      mem_read(0, w, d);
      chk(d == {16'hA000, 16'(w)}, "R9 data", d, {16'hA000, 16'(w)});
    end
    exp_wr = 1;
  endtask

  task automatic t_bad();
    logic [31:0] d;
    send_frame(3, 1, 16'hBAD0);
    chk(irq == 0, "R3 no irq", 32'(irq), 0);
    send_frame(2, 0, 16'hB100);
    check_last("R3 bin reused");
    mem_read(exp_wr, 0, d);
    chk(d == 32'hB1000000, "R3 data in bin", d, 32'hB1000000);
    exp_wr++;
  endtask

  task automatic t_ack();
    logic [31:0] d;
    send_frame(1, 0, 16'hC000);
    exp_wr++;
    reg_write(16'h2008, 32'h1);
    chk(irq == 1, "R5 other write keeps", 32'(irq), 1);
    reg_read(16'h2000, d);
    chk(irq == 1, "R5 other read keeps", 32'(irq), 1);
    chk(d == 0, "R8 other offset", d, 0);
    reg_write(CTRL, 32'h0);
    chk(irq == 0, "R5 write ack", 32'(irq), 0);
    send_frame(1, 0, 16'hC100);
    check_last("R7 zero write no clear");
    exp_wr++;
  endtask

  task automatic t_simul();
    logic [31:0] d;
    rx_valid = 1; rx_eof = 1; rx_data = 32'hD0;
    reg_addr = CTRL; reg_rd = 1;
    @(negedge clk);
    rx_valid = 0; rx_eof = 0; reg_rd = 0;
    chk(irq == 1, "R6 set wins", 32'(irq), 1);
    d = reg_rdata;
    chk(d == {20'b0, 4'(exp_wr - 1), 8'b0}, "R6 old bin read", d,
        {20'b0, 4'(exp_wr - 1), 8'b0});
    exp_wr++;
    reg_read(CTRL, d);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 17; k++) begin
      send_frame(1, 0, 16'hE000);
      check_last("R2 wrap");
      exp_wr = (exp_wr + 1) % 16;
    end
  endtask

  task automatic t_clear();
    release_bins(5);
    reg_write(CTRL, 32'hFFFF_FFFF);
    exp_wr = exp_rd;
    send_frame(1, 0, 16'hF000);
    check_last("R7 R10 clear to rd");
    exp_wr = (exp_wr + 1) % 16;
    release_bins(14);
    reg_write(CTRL, 32'h1);
    exp_wr = exp_rd;
    send_frame(1, 0, 16'hF100);
    check_last("R10 rd wrap");
    exp_wr = (exp_wr + 1) % 16;
  endtask

  task automatic t_long();
    logic [31:0] d;
    int b;
    b = exp_wr;
    send_frame(18, 0, 16'h7700);
    check_last("R11 long frame bin");
    mem_read(b, 15, d);
    chk(d == 32'h7700000F, "R11 last word kept", d, 32'h7700000F);
    mem_read(b, 0, d);
    chk(d == 32'h77000000, "R11 first word", d, 32'h77000000);
    exp_wr = (exp_wr + 1) % 16;
  endtask

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_good();
    t_bad();
    t_ack();
    t_simul();
    t_wrap();
    t_clear();
    t_long();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule